// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between the console buses and the cartridge ROMs. It watches CPU writes to a sixteen-byte register page at 0x7EF0–0x7EFF and keeps a set of bank registers. From them it turns each CPU program fetch into an address in program ROM and each pattern-table fetch into an address in character ROM. It also drives a nametable mirroring select.

Program space is cut into four 8 KB slots. The slots at 0x8000, 0xA000 and 0xC000 each take a bank from a register. The slot at 0xE000 is wired to the last bank. Character space is cut into eight 1 KB slots. One half of it is fed by two 2 KB registers and the other half by four 1 KB registers. A swap bit decides which half each group feeds.

Register writes are captured on the clock edge. The address outputs are combinational in the current bus address and the stored registers. Bank numbers are reduced to the ROM sizes given by parameters, both of which must be powers of two.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the outputs are as follows. Program slots 0..3 (CPU A14:A13 = 0..3) map banks 0, 1, PRG_BANKS-2 and PRG_BANKS-1. Character slots 0..7 (PPU A12:A10) map 1 KB banks 0..7. The swap bit is clear and `mirror_vert` is 1.
- R2: A write to an address outside 0x7EF0–0x7EF6 and 0x7EFA–0x7EFC leaves every output mapping and `mirror_vert` unchanged. This includes the unused addresses 0x7EF7–0x7EF9 and 0x7EFD–0x7EFF.
- R3: A write of D to 0x7EF0 stores D>>1 as a 2 KB bank index K. A write to 0x7EF1 stores index J the same way. With the swap bit clear, slots 0/1 map 1 KB banks 2K/2K+1 and slots 2/3 map 2J/2J+1. With the swap bit set, the same values map slots 4/5 and 6/7.
- R4: A write of D to 0x7EF2, 0x7EF3, 0x7EF4 or 0x7EF5 stores D as a 1 KB bank. Those four registers drive slots 4, 5, 6 and 7 in that order when the swap bit is clear, and slots 0, 1, 2 and 3 when it is set.
- R5: A write of D to 0x7EF6 sets the swap bit to D[1] and `mirror_vert` to D[0] (1 = vertical, 0 = horizontal).
- R6: A write of D to 0x7EFA, 0x7EFB or 0x7EFC sets the program bank of slot 0 (0x8000), slot 1 (0xA000) or slot 2 (0xC000) to D>>2.
- R7: Program slot 3 (0xE000) always maps bank PRG_BANKS-1, whatever has been written.
- R8: Stored bank numbers wrap to the ROM size. A program bank is taken modulo PRG_BANKS, a 1 KB bank modulo CHR_BANKS_1K, and a 2 KB index modulo CHR_BANKS_1K/2.
- R9: Changing the swap bit does not alter any stored bank register. Setting it and then clearing it restores the earlier character mapping.
- R10: `prg_addr` = bank*8192 + CPU A12:A0, and `chr_addr` = bank*1024 + PPU A9:A0.
- R11: While `cpu_wr` is low, a valid register address and data on the write port have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_waddr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_raddr | input | 15 | CPU fetch address A14..A0 within 0x8000–0xFFFF |
| ppu_addr | input | 13 | PPU pattern-space address A12..A0 |
| prg_addr | output | log2(PRG_BANKS)+13 | Program ROM byte address |
| chr_addr | output | log2(CHR_BANKS_1K)+10 | Character ROM byte address |
| mirror_vert | output | 1 | 1 = vertical mirroring, 0 = horizontal |

## Verification
A write presented with `cpu_wr` high is captured at the next rising edge. Its effect on `prg_addr`, `chr_addr` and `mirror_vert` is visible from that edge on. The bench therefore drives each write at a falling edge, drops the strobe at the following falling edge, and only then applies read addresses. The address outputs have no register on the read path, so each lookup is checked one time step after its address is applied, well clear of any rising edge. A reference model updated in the same write task supplies every expected value.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  // Register page: 0x7EF0..0x7EFF
  localparam logic [11:0] REG_PAGE = 12'h7EF;
  localparam logic [3:0] OFS_CHR2K_LO = 4'h0;
  localparam logic [3:0] OFS_CHR2K_HI = 4'h1;
  localparam logic [3:0] OFS_CHR1K_LO = 4'h2;
  localparam logic [3:0] OFS_CHR1K_HI = 4'h5;
  localparam logic [3:0] OFS_CTRL = 4'h6;
  localparam logic [3:0] OFS_PRG_LO = 4'hA;
  localparam logic [3:0] OFS_PRG_HI = 4'hC;

  function automatic logic [7:0] prg_raw_bank(input logic [7:0] d);
    return d >> 2;
  endfunction

  function automatic logic [7:0] chr2k_raw_index(input logic [7:0] d);
    return d >> 1;
  endfunction
endpackage

// File: rtl/cart_map_regs.sv
module cart_map_regs
  import cart_map_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS_1K = 128,
  localparam int PRG_W = $clog2(PRG_BANKS),
  localparam int CHR_W = $clog2(CHR_BANKS_1K)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_wr,
  input  logic [15:0] cpu_waddr,
  input  logic [7:0] cpu_wdata,
  output logic [2:0][PRG_W-1:0] prg_q,
  output logic [1:0][CHR_W-2:0] chr2k_q,
  output logic [3:0][CHR_W-1:0] chr1k_q,
  output logic swap_q,
  output logic mirror_q,
  output logic window_hit
);
  wire [3:0] ofs = cpu_waddr[3:0];
  wire in_page = (cpu_waddr[15:4] == REG_PAGE);
  wire hit_chr2k = in_page && (ofs <= OFS_CHR2K_HI);
  wire hit_chr1k = in_page && (ofs >= OFS_CHR1K_LO) && (ofs <= OFS_CHR1K_HI);
  wire hit_ctrl = in_page && (ofs == OFS_CTRL);
  wire hit_prg = in_page && (ofs >= OFS_PRG_LO) && (ofs <= OFS_PRG_HI);

  assign window_hit = hit_chr2k || hit_chr1k || hit_ctrl || hit_prg;

  wire [7:0] prg_raw = prg_raw_bank(cpu_wdata);
  wire [7:0] c2_raw = chr2k_raw_index(cpu_wdata);
  wire [PRG_W-1:0] prg_d = prg_raw[PRG_W-1:0];
  wire [CHR_W-2:0] c2_d = c2_raw[CHR_W-2:0];
  wire [CHR_W-1:0] c1_d = cpu_wdata[CHR_W-1:0];
  wire [1:0] prg_sel = 2'(ofs - OFS_PRG_LO);
  wire [1:0] c1_sel = 2'(ofs - OFS_CHR1K_LO);

  wire unused_ok = ^{prg_raw, c2_raw, cpu_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_q[0] <= '0;
      prg_q[1] <= PRG_W'(1);
      prg_q[2] <= PRG_W'(PRG_BANKS - 2);
      for (int i = 0; i < 2; i++) chr2k_q[i] <= (CHR_W-1)'(i);
      for (int i = 0; i < 4; i++) chr1k_q[i] <= CHR_W'(4 + i);
      swap_q <= 1'b0;
      mirror_q <= 1'b1;
    end else if (cpu_wr) begin
      if (hit_prg) prg_q[prg_sel] <= prg_d;
      if (hit_chr2k) chr2k_q[ofs[0]] <= c2_d;
      if (hit_chr1k) chr1k_q[c1_sel] <= c1_d;
      if (hit_ctrl) begin
        swap_q <= cpu_wdata[1];
        mirror_q <= cpu_wdata[0];
      end
    end
  end
endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map #(
  parameter int PRG_BANKS = 16,
  localparam int PRG_W = $clog2(PRG_BANKS)
) (
  input  logic [14:0] cpu_raddr,
  input  logic [2:0][PRG_W-1:0] prg_q,
  output logic [PRG_W+12:0] prg_addr
);
  localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_BANKS - 1);
  logic [PRG_W-1:0] bank;

  always_comb begin
    unique case (cpu_raddr[14:13])
      2'd0: bank = prg_q[0];
      2'd1: bank = prg_q[1];
      2'd2: bank = prg_q[2];
      default: bank = LAST_BANK;
    endcase
  end

  assign prg_addr = {bank, cpu_raddr[12:0]};
endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map #(
  parameter int CHR_BANKS_1K = 128,
  localparam int CHR_W = $clog2(CHR_BANKS_1K)
) (
  input  logic [12:0] ppu_addr,
  input  logic swap_q,
  input  logic [1:0][CHR_W-2:0] chr2k_q,
  input  logic [3:0][CHR_W-1:0] chr1k_q,
  output logic [CHR_W+9:0] chr_addr
);
  wire [2:0] slot = ppu_addr[12:10];
  // The half whose top bit equals the swap bit is fed by the 2 KB pair.
  wire from_2k = (slot[2] == swap_q);
  wire [CHR_W-1:0] bank_2k = {chr2k_q[slot[1]], slot[0]};
  wire [CHR_W-1:0] bank_1k = chr1k_q[slot[1:0]];
  wire [CHR_W-1:0] bank = from_2k ? bank_2k : bank_1k;

  assign chr_addr = {bank, ppu_addr[9:0]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS_1K = 128,
  localparam int PRG_W = $clog2(PRG_BANKS),
  localparam int CHR_W = $clog2(CHR_BANKS_1K)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_wr,
  input  logic [15:0] cpu_waddr,
  input  logic [7:0] cpu_wdata,
  input  logic [14:0] cpu_raddr,
  input  logic [12:0] ppu_addr,
  output logic [PRG_W+12:0] prg_addr,
  output logic [CHR_W+9:0] chr_addr,
  output logic mirror_vert
);
  logic [2:0][PRG_W-1:0] prg_q;
  logic [1:0][CHR_W-2:0] chr2k_q;
  logic [3:0][CHR_W-1:0] chr1k_q;
  logic swap_q;
  logic window_hit;

  cart_map_regs #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS_1K(CHR_BANKS_1K)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_waddr(cpu_waddr),
    .cpu_wdata(cpu_wdata), .prg_q(prg_q), .chr2k_q(chr2k_q), .chr1k_q(chr1k_q),
    .swap_q(swap_q), .mirror_q(mirror_vert), .window_hit(window_hit)
  );

  cart_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .cpu_raddr(cpu_raddr), .prg_q(prg_q), .prg_addr(prg_addr)
  );

  cart_chr_map #(.CHR_BANKS_1K(CHR_BANKS_1K)) u_chr (
    .ppu_addr(ppu_addr), .swap_q(swap_q), .chr2k_q(chr2k_q),
    .chr1k_q(chr1k_q), .chr_addr(chr_addr)
  );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS_1K = 128,
  localparam int PRG_W = $clog2(PRG_BANKS),
  localparam int CHR_W = $clog2(CHR_BANKS_1K)
) (
  input logic clk,
  input logic rst_n,
  input logic cpu_wr,
  input logic [15:0] cpu_waddr,
  input logic [7:0] cpu_wdata,
  input logic [14:0] cpu_raddr,
  input logic [12:0] ppu_addr,
  input logic [PRG_W+12:0] prg_addr,
  input logic [CHR_W+9:0] chr_addr,
  input logic mirror_vert,
  input logic [2:0][PRG_W-1:0] prg_q,
  input logic [1:0][CHR_W-2:0] chr2k_q,
  input logic [3:0][CHR_W-1:0] chr1k_q,
  input logic swap_q,
  input logic window_hit
);
  wire [7:0] wd_sh2 = cpu_wdata >> 2;
  wire [PRG_W-1:0] wd_prg = wd_sh2[PRG_W-1:0];

  // R2: a write outside the window changes no state
  a_r2_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !window_hit) |=> ($stable(prg_q) && $stable(chr2k_q) &&
      $stable(chr1k_q) && $stable(swap_q) && $stable(mirror_vert)));

  // R3: in the 2 KB half the slot's low bit passes straight to bank bit 0
  a_r3_pair_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_addr[12] == swap_q) |-> (chr_addr[10] == ppu_addr[10]));

  // R5: control write latches swap and mirroring
  a_r5_ctrl_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_waddr == 16'h7EF6) |=>
      (swap_q == $past(cpu_wdata[1]) && mirror_vert == $past(cpu_wdata[0])));

  // R6: second program register takes data >> 2
  a_r6_prg_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_waddr == 16'h7EFB) |=> (prg_q[1] == $past(wd_prg)));

  // R7: top slot pinned to the last bank
  a_r7_fixed_last: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_raddr[14:13] == 2'b11) |-> (prg_addr[PRG_W+12:13] == PRG_W'(PRG_BANKS - 1)));

  // R9: control write leaves bank registers alone
  a_r9_swap_keeps_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_waddr == 16'h7EF6) |=>
      ($stable(prg_q) && $stable(chr2k_q) && $stable(chr1k_q)));

  // R10: in-bank offsets pass through unchanged
  a_r10_offsets: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_addr[9:0] == ppu_addr[9:0]) && (prg_addr[12:0] == cpu_raddr[12:0]));

  // R11: no strobe, no state change
  a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($stable(prg_q) && $stable(chr2k_q) && $stable(chr1k_q) &&
      $stable(swap_q) && $stable(mirror_vert)));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
  .PRG_BANKS(PRG_BANKS), .CHR_BANKS_1K(CHR_BANKS_1K)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_waddr(cpu_waddr),
  .cpu_wdata(cpu_wdata), .cpu_raddr(cpu_raddr), .ppu_addr(ppu_addr),
  .prg_addr(prg_addr), .chr_addr(chr_addr), .mirror_vert(mirror_vert),
  .prg_q(prg_q), .chr2k_q(chr2k_q), .chr1k_q(chr1k_q), .swap_q(swap_q),
  .window_hit(window_hit)
);

// File: tb/tb_cart_bank_mapper.sv
`timescale 1ns/1ps
module tb_cart_bank_mapper;
  localparam int PRG_BANKS = 16;
  localparam int CHR_BANKS_1K = 128;
  localparam int PRG_W = $clog2(PRG_BANKS);
  localparam int CHR_W = $clog2(CHR_BANKS_1K);

  logic clk = 0;
  logic rst_n = 0;
  logic cpu_wr = 0;
  logic [15:0] cpu_waddr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [14:0] cpu_raddr = 0;
  logic [12:0] ppu_addr = 0;
  logic [PRG_W+12:0] prg_addr;
  logic [CHR_W+9:0] chr_addr;
  logic mirror_vert;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_prg[3];
  int m_c2[2];
  int m_c1[4];
  int m_swap;
  int m_mir;

  always #10 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS_1K(CHR_BANKS_1K)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_waddr(cpu_waddr),
    .cpu_wdata(cpu_wdata), .cpu_raddr(cpu_raddr), .ppu_addr(ppu_addr),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .mirror_vert(mirror_vert)
  );

  function automatic int exp_prg(input int a);
    int slot = (a / 8192) % 4;
    int bank = (slot == 3) ? PRG_BANKS - 1 : m_prg[slot];
    return bank * 8192 + (a % 8192);
  endfunction

  function automatic int exp_chr(input int a);
    int slot = (a / 1024) % 8;
    int bank;
    if ((slot / 4) == m_swap) bank = m_c2[(slot / 2) % 2] * 2 + (slot % 2);
    else bank = m_c1[slot % 4];
    return bank * 1024 + (a % 1024);
  endfunction

  task automatic model_reset();
    m_prg[0] = 0; m_prg[1] = 1; m_prg[2] = PRG_BANKS - 2;
    m_c2[0] = 0; m_c2[1] = 1;
    for (int i = 0; i < 4; i++) m_c1[i] = 4 + i;
    m_swap = 0; m_mir = 1;
  endtask

  task automatic model_write(input int a, input int d);
    if (a == 'h7EF0 || a == 'h7EF1) m_c2[a - 'h7EF0] = (d / 2) % (CHR_BANKS_1K / 2);
    else if (a >= 'h7EF2 && a <= 'h7EF5) m_c1[a - 'h7EF2] = d % CHR_BANKS_1K;
    else if (a == 'h7EF6) begin m_swap = (d / 2) % 2; m_mir = d % 2; end
    else if (a >= 'h7EFA && a <= 'h7EFC) m_prg[a - 'h7EFA] = (d / 4) % PRG_BANKS;
  endtask

  task automatic do_write(input int a, input int d);
    @(negedge clk);
    cpu_waddr = 16'(a); cpu_wdata = 8'(d); cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
    model_write(a, d);
  endtask

  task automatic chk_prg(input int a, input string tag);
    int exp;
    cpu_raddr = 15'(a);
    #1;
    exp = exp_prg(a);
    checks++;
    if (int'(prg_addr) != exp) begin
      failures++;
      $display("FAIL %s prg raddr=%h actual=%h expected=%h", tag, a, prg_addr, exp);
    end
  endtask

  task automatic chk_chr(input int a, input string tag);
    int exp;
    ppu_addr = 13'(a);
    #1;
    exp = exp_chr(a);
    checks++;
    if (int'(chr_addr) != exp) begin
      failures++;
      $display("FAIL %s chr paddr=%h actual=%h expected=%h", tag, a, chr_addr, exp);
    end
  endtask

  task automatic chk_mir(input string tag);
    #1;
    checks++;
    if (int'(mirror_vert) != m_mir) begin
      failures++;
      $display("FAIL %s mirror actual=%0d expected=%0d", tag, mirror_vert, m_mir);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int s = 0; s < 4; s++) chk_prg(s * 8192 + 'h123 + s, tag);
    for (int s = 0; s < 8; s++) chk_chr(s * 1024 + 'h2A + s * 3, tag);
    chk_mir(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset map, R7 top slot fixed
    chk_all("R1");
    chk_prg('h6ABC, "R7");
    // R2 unused and outside addresses
    do_write('h7EF7, 'hFF); do_write('h7EF9, 'hFF); do_write('h7EFD, 'hFF);
    do_write('h7EEF, 'hFF); do_write('h7F00, 'hFF); do_write('hFEFA, 'hFF);
    chk_all("R2");
    // R11 strobe low
    @(negedge clk);
    cpu_waddr = 16'h7EFA; cpu_wdata = 8'hFF; cpu_wr = 0;
    repeat (2) @(negedge clk);
    cpu_waddr = 16'h7EF6; cpu_wdata = 8'h02;
    repeat (2) @(negedge clk);
    chk_all("R11");
    // R3 2 KB registers, swap clear
    do_write('h7EF0, 'h0A); do_write('h7EF1, 'h0F);
    chk_all("R3");
    // R4 1 KB registers, swap clear
    do_write('h7EF2, 'h20); do_write('h7EF3, 'h21);
    do_write('h7EF4, 'h30); do_write('h7EF5, 'h7F);
    chk_all("R4");
    // R5 swap set, horizontal mirroring
    do_write('h7EF6, 'h02);
    chk_all("R5");
    do_write('h7EF1, 'h44); do_write('h7EF3, 'h11);
    chk_all("R3_swapped");
    chk_all("R4_swapped");
    // R9 clearing swap restores sides
    do_write('h7EF6, 'h01);
    chk_all("R9");
    // R6 program registers
    do_write('h7EFA, 'h0C); do_write('h7EFB, 'h17); do_write('h7EFC, 'h20);
    chk_all("R6");
    chk_prg('h7FFF, "R7");
    // R8 wrap to ROM size
    do_write('h7EFA, 'hFF); do_write('h7EF2, 'hC5); do_write('h7EF0, 'hFF);
    chk_all("R8");
    // R10 offsets at slot edges
    chk_prg('h0000, "R10"); chk_prg('h1FFF, "R10"); chk_prg('h5FFF, "R10");
    chk_chr('h0000, "R10"); chk_chr('h03FF, "R10"); chk_chr('h1FFF, "R10");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int a = 'h7EE8 + int'($urandom % 40);
      int d = int'($urandom % 256);
      do_write(a, d);
      chk_prg(int'($urandom % 32768), "R10_rand");
      chk_chr(int'($urandom % 8192), "R10_rand");
      if ((n % 16) == 0) chk_mir("R5_rand");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule